// File: doc/BRIEF.md
# Mask-Programmable Base Address Register

This block holds one PCI configuration base address register together with a companion mask register that software writes. The mask is not fixed in hardware. Its upper bits, 31 down to 4, choose which base bits are programmable and so set the window size. Its lowest bit chooses memory or I/O space. For memory space, bits 3:1 of the mask supply the prefetchable flag and the placement type, and these are reflected in the base read-back.

A simple configuration port carries read, write, a one-bit register select, four byte enables and 32-bit data. A read returns data one cycle later. Bus cycles are offered as an address, a space flag and a valid strobe, and a registered hit result follows one cycle later.

Rewriting the mask marks the base as stale. No hit is produced until software writes the base again.

Top module: `mpbar_top`

## Requirements
- R1: After synchronous reset the mask reads FFFFFFC1h and the base reads 00000001h: the stored base is zero and the low bits come from the I/O mask.
- R2: A mask write (cfg_sel=1) updates only the byte lanes whose cfg_be bit is set, where bit n covers data bits 8n+7:8n. A mask read returns all 32 stored bits.
- R3: A base write (cfg_sel=0) updates only the enabled byte lanes. It stores a bit in 31:4 only where the mask bit is 1, so base read-back bits 31:4 are always zero wherever the mask is zero.
- R4: Base read-back bits 3:0 never come from base writes. With mask bit 0 = 0 (memory) they read {mask[3:1],0}. With mask bit 0 = 1 (I/O) they read 0001b.
- R5: A mask write clears every stored base bit in 31:4 that the new mask forces to zero.
- R6: A mask write makes the base stale from the next cycle onward. While the base is stale, bus_hit stays 0. The next base write clears the stale state. Reset leaves the base not stale.
- R7: One cycle after a cycle with bus_valid=1, bus_hit is 1 exactly when bus_io equals mask bit 0, the base is not stale, and bus_addr and the base agree in every bit of 31:4 where the mask is 1. Otherwise bus_hit is 0.
- R8: A bus cycle whose space flag differs from mask bit 0 never produces a hit, even when the address matches.
- R9: cfg_rdata is loaded on the clock edge where cfg_rd=1, using the register contents before any write in that same cycle. It holds its value while cfg_rd=0.
- R10: With mask FFFFFFF0h the window is 16 bytes. All 16 addresses of the aligned block at the base hit, and the addresses just outside it do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 mask |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| bus_valid | input | 1 | Bus cycle present |
| bus_io | input | 1 | Bus cycle space: 0 memory, 1 I/O |
| bus_addr | input | 32 | Bus cycle address |
| bus_hit | output | 1 | Registered decode result |

## Verification
Both results of this block are due exactly one clock edge after their stimulus. Read data reflects the register state in front of that edge. The hit result uses the mask, base and stale state as they stood at the edge where the bus cycle was sampled. The bench drives inputs on the falling edge and reads outputs on the following falling edge, so each result is taken one rising edge after its cause. A behavioural model is advanced on the same rising edge and compared with both outputs on every falling edge. Writes become visible to a read or a bus probe issued on the cycle after the write.

// File: rtl/mpbar_pkg.sv
package mpbar_pkg;

    localparam int DW      = 32;
    localparam int NBYTES  = DW / 8;
    localparam int LOW_W   = 4;
    localparam logic [DW-1:0] MASK_RESET = 32'hFFFF_FFC1;
    localparam logic [DW-1:0] BASE_RESET = 32'h0000_0000;

    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_MASK = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        cfg_sel_e          sel;
        logic [NBYTES-1:0] be;
        logic [DW-1:0]     data;
    } cfg_req_t;

    typedef struct packed {
        logic          valid;
        logic          is_io;
        logic [DW-1:0] addr;
    } bus_req_t;

    // Read-only low bits of the base, derived from the mask.
    function automatic logic [LOW_W-1:0] type_bits(input logic [DW-1:0] m);
        return m[0] ? LOW_W'(1) : {m[LOW_W-1:1], 1'b0};
    endfunction

    // Address bits that take part in decode.
    function automatic logic [DW-1:0] window_of(input logic [DW-1:0] m);
        return {m[DW-1:LOW_W], {LOW_W{1'b0}}};
    endfunction

endpackage

// File: rtl/mpbar_regs.sv
module mpbar_regs
    import mpbar_pkg::*;
#(
    parameter logic [DW-1:0] MASK_RST = MASK_RESET,
    parameter logic [DW-1:0] BASE_RST = BASE_RESET
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_req_t      req,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] base_q,
    output logic          stale_q
);

    logic          mask_we;
    logic          base_we;
    logic [DW-1:0] mask_nxt;
    logic [DW-1:0] base_mrg;

    assign mask_we = req.wr && (req.sel == SEL_MASK);
    assign base_we = req.wr && (req.sel == SEL_BASE);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign mask_nxt[b*8 +: 8] = (mask_we && req.be[b]) ? req.data[b*8 +: 8]
                                                           : mask_q[b*8 +: 8];
        assign base_mrg[b*8 +: 8] = (base_we && req.be[b]) ? req.data[b*8 +: 8]
                                                           : base_q[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= MASK_RST;
            base_q  <= BASE_RST & window_of(MASK_RST);
            stale_q <= 1'b0;
        end else if (mask_we) begin
            mask_q  <= mask_nxt;
            base_q  <= base_q & window_of(mask_nxt);
            stale_q <= 1'b1;
        end else if (base_we) begin
            base_q  <= base_mrg & window_of(mask_q);
            stale_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mpbar_readback.sv
module mpbar_readback
    import mpbar_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cfg_req_t      req,
    input  logic [DW-1:0] mask_q,
    input  logic [DW-1:0] base_q,
    output logic [DW-1:0] rdata_q
);

    logic [DW-1:0] base_view;

    assign base_view = base_q | {{(DW-LOW_W){1'b0}}, type_bits(mask_q)};

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd) begin
            rdata_q <= (req.sel == SEL_MASK) ? mask_q : base_view;
        end
    end

endmodule

// File: rtl/mpbar_decode.sv
module mpbar_decode
    import mpbar_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      bus,
    input  logic [DW-1:0] mask_q,
    input  logic [DW-1:0] base_q,
    input  logic          stale_q,
    output logic          hit_q
);

    logic space_ok;
    logic addr_ok;

    assign space_ok = (bus.is_io == mask_q[0]);
    assign addr_ok  = ((bus.addr ^ base_q) & window_of(mask_q)) == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= bus.valid && space_ok && addr_ok && !stale_q;
        end
    end

endmodule

// File: rtl/mpbar_top.sv
module mpbar_top
    import mpbar_pkg::*;
#(
    parameter logic [DW-1:0] MASK_RST = MASK_RESET,
    parameter logic [DW-1:0] BASE_RST = BASE_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic              cfg_sel,
    input  logic [NBYTES-1:0] cfg_be,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              bus_valid,
    input  logic              bus_io,
    input  logic [DW-1:0]     bus_addr,
    output logic              bus_hit
);

    cfg_req_t      req;
    bus_req_t      bus;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] base_q;
    logic          stale_q;

    assign req = '{wr: cfg_wr, rd: cfg_rd, sel: cfg_sel_e'(cfg_sel),
                   be: cfg_be, data: cfg_wdata};
    assign bus = '{valid: bus_valid, is_io: bus_io, addr: bus_addr};

    mpbar_regs #(
        .MASK_RST (MASK_RST),
        .BASE_RST (BASE_RST)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .mask_q  (mask_q),
        .base_q  (base_q),
        .stale_q (stale_q)
    );

    mpbar_readback u_rb (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .mask_q  (mask_q),
        .base_q  (base_q),
        .rdata_q (cfg_rdata)
    );

    mpbar_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .mask_q  (mask_q),
        .base_q  (base_q),
        .stale_q (stale_q),
        .hit_q   (bus_hit)
    );

endmodule

// File: rtl/mpbar_chk.sv
module mpbar_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic        cfg_rd,
    input logic        cfg_sel,
    input logic [31:0] cfg_rdata,
    input logic        bus_valid,
    input logic        bus_io,
    input logic        bus_hit,
    input logic [31:0] mask_q,
    input logic        stale_q
);

    AST_MASKWR_STALE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_sel) |=> stale_q); // R6

    AST_STALE_NOHIT: assert property (@(posedge clk) disable iff (rst)
        stale_q |=> !bus_hit); // R6

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        bus_hit |-> $past(bus_valid)); // R7

    AST_HIT_SPACE: assert property (@(posedge clk) disable iff (rst)
        bus_hit |-> ($past(bus_io) == $past(mask_q[0]))); // R8

    AST_RD_LOW_MEM: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && !$past(cfg_sel) && !$past(mask_q[0]))
        |-> (cfg_rdata[3:0] == {$past(mask_q[3:1]), 1'b0})); // R4

    AST_RD_LOW_IO: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && !$past(cfg_sel) && $past(mask_q[0]))
        |-> (cfg_rdata[3:0] == 4'b0001)); // R4

    AST_RD_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && !$past(cfg_sel))
        |-> ((cfg_rdata[31:4] & ~$past(mask_q[31:4])) == '0)); // R3

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_rd) |-> $stable(cfg_rdata)); // R9

endmodule

bind mpbar_top mpbar_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata),
    .bus_valid (bus_valid),
    .bus_io    (bus_io),
    .bus_hit   (bus_hit),
    .mask_q    (mask_q),
    .stale_q   (stale_q)
);

// File: tb/mpbar_top_tb.sv
module mpbar_top_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic        bus_io = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_hit;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    mpbar_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_sel   (cfg_sel),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bus_valid (bus_valid),
        .bus_io    (bus_io),
        .bus_addr  (bus_addr),
        .bus_hit   (bus_hit)
    );

    // Behavioural reference model
    logic [31:0] m_mask, m_base, m_rdata;
    logic        m_stale, m_hit;

    always @(posedge clk) begin
        logic [31:0] win, nm, nb;
        if (rst) begin
            m_mask = 32'hFFFF_FFC1; m_base = 0; m_stale = 0;
            m_rdata = 0; m_hit = 0;
        end else begin
            win   = m_mask & 32'hFFFF_FFF0;
            m_hit = bus_valid && (bus_io == m_mask[0]) && !m_stale &&
                    (((bus_addr ^ m_base) & win) == 0);
            if (cfg_rd)
                m_rdata = cfg_sel ? m_mask
                        : (m_base | (m_mask[0] ? 32'h1 : {28'h0, m_mask[3:1], 1'b0}));
            if (cfg_wr) begin
                nm = m_mask; nb = m_base;
                for (int i = 0; i < 4; i++)
                    if (cfg_be[i]) begin
                        if (cfg_sel) nm[i*8 +: 8] = cfg_wdata[i*8 +: 8];
                        else         nb[i*8 +: 8] = cfg_wdata[i*8 +: 8];
                    end
                if (cfg_sel) begin
                    m_mask = nm; m_base = m_base & nm & 32'hFFFF_FFF0; m_stale = 1;
                end else begin
                    m_base = nb & m_mask & 32'hFFFF_FFF0; m_stale = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R9 model rdata", cfg_rdata, m_rdata);
            chk("R7 model hit", {31'h0, bus_hit}, {31'h0, m_hit});
        end
    end

    task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0; cfg_be = 0;
    endtask

    task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
        cfg_rd = 1; cfg_sel = sel;
        @(negedge clk);
        cfg_rd = 0;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic probe(input logic io, input logic [31:0] a, input logic exp, input string tag);
        bus_valid = 1; bus_io = io; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        chk(tag, {31'h0, bus_hit}, {31'h0, exp});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++; n_err++;
        $display("FAIL R7 watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset rdata", cfg_rdata, 32'h0);
        chk("R1 reset hit", {31'h0, bus_hit}, 32'h0);
        rd(1, 32'hFFFF_FFC1, "R1 mask reset");
        rd(0, 32'h0000_0001, "R1 R4 base reset");
        probe(1, 32'h0000_0030, 1, "R7 reset window io");

        wr(1, 4'hF, 32'hFFFF_F008);
        rd(0, 32'h0000_0008, "R4 memory low bits");
        wr(0, 4'hF, 32'h1234_5FFF);
        rd(0, 32'h1234_5008, "R3 R4 base masked write");
        probe(0, 32'h1234_5ABC, 1, "R7 hit in window");
        probe(0, 32'h1234_6000, 0, "R7 miss outside");
        probe(1, 32'h1234_5ABC, 0, "R8 space mismatch");
        chk("R9 hold", cfg_rdata, 32'h1234_5008);

        wr(1, 4'b0100, 32'h0);
        rd(1, 32'hFF00_F008, "R2 mask byte lane");
        rd(0, 32'h1200_5008, "R5 base trimmed");
        probe(0, 32'h1200_5000, 0, "R6 stale no hit");
        wr(0, 4'hF, 32'h1200_5000);
        probe(0, 32'h1200_5000, 1, "R6 hit after rewrite");

        wr(0, 4'b0001, 32'hFFFF_FFFF);
        rd(0, 32'h1200_5008, "R3 lane0 no effect");
        wr(0, 4'b1000, 32'hAA00_0000);
        rd(0, 32'hAA00_5008, "R3 lane3 write");

        wr(1, 4'hF, 32'hFFFF_FFF0);
        wr(0, 4'hF, 32'h00AB_CDE0);
        rd(0, 32'h00AB_CDE0, "R10 base 16B");
        probe(0, 32'h00AB_CDE0, 1, "R10 low edge");
        probe(0, 32'h00AB_CDEF, 1, "R10 high edge");
        probe(0, 32'h00AB_CDF0, 0, "R10 above");
        probe(0, 32'h00AB_CDDF, 0, "R10 below");

        wr(1, 4'hF, 32'hFFFF_FF01);
        rd(0, 32'h00AB_CD01, "R4 R5 io view");
        wr(0, 4'hF, 32'h0000_1234);
        rd(0, 32'h0000_1201, "R4 io base");
        probe(1, 32'h0000_12FF, 1, "R7 io hit");
        probe(0, 32'h0000_12FF, 0, "R8 memory on io bar");

        cfg_rd = 1; cfg_sel = 0; cfg_wr = 1; cfg_be = 4'hF; cfg_wdata = 32'h0000_3400;
        @(negedge clk);
        cfg_rd = 0; cfg_wr = 0; cfg_be = 0;
        chk("R9 read before write", cfg_rdata, 32'h0000_1201);
        rd(0, 32'h0000_3401, "R9 write landed");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule